// File: doc/BRIEF.md
# Banked Local Memory Conflict Serializer

This block sits in front of a 32-bank shared local memory and turns one wide request into a sequence of per-bank accesses. A request carries up to 32 lane byte-addresses and a valid bit for each lane. The bank of a lane is taken from the word-address bits just above the byte offset. Lanes that hit the same bank at the same word share one access, which is a broadcast. Lanes that hit the same bank at different higher addresses must wait for later cycles.

Once a request is accepted, the block issues one access set per cycle. In each cycle every bank may be enabled with one row address, and a per-lane mask shows which lanes that cycle serves. Served lanes leave a pending mask. The request finishes when that mask is empty. The number of cycles equals the largest number of distinct words that any single bank must deliver. In the worst case this is one word per cycle for the whole request. The storage arrays and the data return path are not part of this block.

Top module: `lmc_conflict_serializer`

## Requirements
- R1: The bank of a lane is address bits [6:2]. In every issue cycle `bank_en[b]` is high exactly when some pending lane maps to bank b. `bank_row` slot b then carries address bits [ADDR_W-1:7] of the word served there, and carries zero when the bank is idle.
- R2: Address bits [1:0] play no part in bank choice or conflict detection. Lanes that differ only in those bits are served together.
- R3: Two valid lanes with the same bank but different bits [ADDR_W-1:7] are served in different cycles.
- R4: All pending lanes with the same bank and the same bits [ADDR_W-1:7] are served in the same cycle, in a single bank access.
- R5: A request with at least one valid lane takes exactly as many issue cycles as the largest count of distinct words (bits [ADDR_W-1:2]) found in any one bank. This reaches 32 when all lanes hit one bank at distinct words.
- R6: In each issue cycle every bank serves the word of its lowest-numbered pending lane. `lane_served` is high for exactly the lanes served in that cycle, and those lanes are not served again.
- R7: `ready` is high when idle and in the final issue cycle of a request, and low in every other issue cycle. A request is taken only on a clock edge where `req_valid` and `ready` are both high. Request inputs presented while `ready` is low have no effect on the outputs.
- R8: `done` is high exactly in the issue cycle after which no pending lane remains. A request with no valid lanes issues for one cycle with no bank enabled and `done` high.
- R9: Lanes whose valid bit was low at acceptance are never served. Every valid lane is served exactly once.
- R10: After reset `ready` is high and `done` and `issue_valid` are low. `issue_valid` is high in an issue cycle exactly when at least one bank is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_lane_valid | input | LANES | Per-lane valid bits of the request |
| req_addr | input | LANES*ADDR_W | Lane byte-addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| ready | output | 1 | A request can be taken on this edge |
| issue_valid | output | 1 | At least one bank is accessed this cycle |
| bank_en | output | 32 | Per-bank access enable for this cycle |
| bank_row | output | 32*(ADDR_W-7) | Row (address bits [ADDR_W-1:7]) per bank, bank b at bits [b*(ADDR_W-7) +: ADDR_W-7] |
| lane_served | output | LANES | Lanes served this cycle |
| done | output | 1 | Last issue cycle of the current request |

## Verification
Contiguous word strides spread the lanes over all banks and must finish in one cycle. A single shared word, and one word reached through different byte offsets, show that broadcast merging works and that bits [1:0] are ignored. A stride of 128 bytes puts every lane in bank 0 at a distinct row and forces the 32-cycle worst case. A two-row interleave and sparse valid masks with conflicting invalid lanes separate real conflicts from lanes that must be skipped. Random addresses drawn from narrow and wide ranges, with garbage requests held on the inputs while busy, check the lowest-lane order and the cycle count against an independent model.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  // byte offset inside a word, then bank index, then row
  localparam int WORD_LSB = 2;
  localparam int BANK_W   = 5;
  localparam int NBANKS   = 1 << BANK_W;
  localparam int ROW_LSB  = WORD_LSB + BANK_W;

  typedef enum logic {ST_IDLE = 1'b0, ST_ISSUE = 1'b1} lmc_state_e;
endpackage

// File: rtl/lmc_lane_decode.sv
module lmc_lane_decode #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 16,
  localparam int ROW_W = ADDR_W - lmc_pkg::ROW_LSB
) (
  input  logic [LANES*ADDR_W-1:0]         addr_flat,
  output logic [LANES*lmc_pkg::BANK_W-1:0] bank_flat,
  output logic [LANES*ROW_W-1:0]          row_flat
);
  import lmc_pkg::*;

  // bank index: word address modulo bank count
  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[ROW_LSB-1:WORD_LSB];
  endfunction

  // row: everything above the bank field
  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ROW_LSB];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bank_flat[g*BANK_W +: BANK_W] = bank_of(addr_flat[g*ADDR_W +: ADDR_W]);
    assign row_flat[g*ROW_W +: ROW_W]    = row_of(addr_flat[g*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/lmc_bank_pick.sv
module lmc_bank_pick #(
  parameter int LANES   = 32,
  parameter int ROW_W   = 9,
  parameter int BANK_ID = 0,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]                 pend,
  input  logic [LANES*lmc_pkg::BANK_W-1:0] bank_flat,
  input  logic [LANES*ROW_W-1:0]           row_flat,
  output logic                             en,
  output logic [ROW_W-1:0]                 row,
  output logic [LANES-1:0]                 hit
);
  import lmc_pkg::*;

  logic [LANES-1:0]  mine;
  logic [LANE_W-1:0] sel;

  // lanes still pending that target this bank
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      mine[i] = pend[i] && (bank_flat[i*BANK_W +: BANK_W] == BANK_W'(BANK_ID));
    end
  end

  // lowest-numbered candidate wins: scan downward so the last write is the lowest
  always_comb begin
    en  = 1'b0;
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mine[i]) begin
        en  = 1'b1;
        sel = LANE_W'(i);
      end
    end
  end

  assign row = en ? row_flat[sel*ROW_W +: ROW_W] : '0;

  // broadcast: every candidate on the chosen row is served together
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      hit[i] = en && mine[i] && (row_flat[i*ROW_W +: ROW_W] == row);
    end
  end
endmodule

// File: rtl/lmc_issue_ctrl.sv
module lmc_issue_ctrl #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [LANES-1:0]        req_lane_valid,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        served,
  output logic                    busy,
  output logic [LANES-1:0]        pending,
  output logic [LANES*ADDR_W-1:0] addr_q,
  output logic                    done,
  output logic                    ready,
  output logic                    accept
);
  import lmc_pkg::*;

  lmc_state_e       state_q;
  logic [LANES-1:0] remain;

  assign busy   = (state_q == ST_ISSUE);
  assign remain = pending & ~served;
  assign done   = busy && (remain == '0);
  assign ready  = !busy || done;
  assign accept = ready && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pending <= '0;
      addr_q  <= '0;
    end else if (accept) begin
      state_q <= ST_ISSUE;
      pending <= req_lane_valid;
      addr_q  <= req_addr;
    end else if (done) begin
      state_q <= ST_IDLE;
      pending <= '0;
    end else if (busy) begin
      pending <= remain;
    end
  end
endmodule

// File: rtl/lmc_conflict_serializer.sv
module lmc_conflict_serializer #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 16,
  localparam int NB    = lmc_pkg::NBANKS,
  localparam int ROW_W = ADDR_W - lmc_pkg::ROW_LSB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [LANES-1:0]        req_lane_valid,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    ready,
  output logic                    issue_valid,
  output logic [NB-1:0]           bank_en,
  output logic [NB*ROW_W-1:0]     bank_row,
  output logic [LANES-1:0]        lane_served,
  output logic                    done
);
  import lmc_pkg::*;

  logic                    busy_w;
  logic                    accept_w;
  logic [LANES-1:0]        pending_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*BANK_W-1:0] bank_flat;
  logic [LANES*ROW_W-1:0]  row_flat;
  logic [LANES-1:0]        hit_m [NB];
  logic [LANES-1:0]        served_w;

  lmc_issue_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_lane_valid (req_lane_valid),
    .req_addr       (req_addr),
    .served         (served_w),
    .busy           (busy_w),
    .pending        (pending_q),
    .addr_q         (addr_q),
    .done           (done),
    .ready          (ready),
    .accept         (accept_w)
  );

  lmc_lane_decode #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dec (
    .addr_flat (addr_q),
    .bank_flat (bank_flat),
    .row_flat  (row_flat)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    lmc_bank_pick #(.LANES(LANES), .ROW_W(ROW_W), .BANK_ID(b)) u_pick (
      .pend      (pending_q),
      .bank_flat (bank_flat),
      .row_flat  (row_flat),
      .en        (bank_en[b]),
      .row       (bank_row[b*ROW_W +: ROW_W]),
      .hit       (hit_m[b])
    );
  end

  // union of per-bank service masks
  always_comb begin
    served_w = '0;
    for (int b = 0; b < NB; b++) begin
      served_w = served_w | hit_m[b];
    end
  end

  assign lane_served = served_w;
  assign issue_valid = busy_w && (bank_en != '0);
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             ready,
  input logic             accept,
  input logic [LANES-1:0] pending,
  input logic [LANES-1:0] served
);
  // only pending lanes may be served
  assert_served_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((served & ~pending) == '0));

  // every issue cycle with work left makes progress
  assert_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pending != '0) |-> (served != '0));

  // no new request while a multi-cycle one is in flight
  assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> !ready);

  // pending never gains lanes except on acceptance
  assert_no_new_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> ((pending & ~$past(pending)) == '0));

  // done only while issuing, and the block goes idle after it
  assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !busy);

  // served lanes never outnumber pending ones
  assert_served_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(served) <= $countones(pending)));
endmodule

bind lmc_conflict_serializer lmc_checker #(.LANES(LANES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy_w),
  .done    (done),
  .ready   (ready),
  .accept  (accept_w),
  .pending (pending_q),
  .served  (served_w)
);

// File: tb/lmc_conflict_serializer_tb.sv
`timescale 1ns/1ps
module lmc_conflict_serializer_tb;
  localparam int LANES  = 32;
  localparam int ADDR_W = 16;
  localparam int NB     = 32;
  localparam int ROW_W  = ADDR_W - 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LANES-1:0] req_lane_valid = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic ready, issue_valid, done;
  logic [NB-1:0] bank_en;
  logic [NB*ROW_W-1:0] bank_row;
  logic [LANES-1:0] lane_served;

  int errors = 0;
  int checks = 0;

  logic [ADDR_W-1:0] a [LANES];
  logic [LANES-1:0]  lv;

  always #2 clk = ~clk;

  lmc_conflict_serializer #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_lane_valid(req_lane_valid), .req_addr(req_addr),
    .ready(ready), .issue_valid(issue_valid), .bank_en(bank_en),
    .bank_row(bank_row), .lane_served(lane_served), .done(done)
  );

  function automatic int bank_f(input logic [ADDR_W-1:0] x);
    return (int'(x) / 4) % 32;
  endfunction

  function automatic int row_f(input logic [ADDR_W-1:0] x);
    return int'(x) / 128;
  endfunction

  // largest number of distinct words within one bank, at least one
  function automatic int exp_cycles();
    int cnt [NB];
    int mx = 0;
    for (int b = 0; b < NB; b++) cnt[b] = 0;
    for (int i = 0; i < LANES; i++) begin
      if (lv[i]) begin
        bit seen = 0;
        for (int j = 0; j < i; j++)
          if (lv[j] && (a[j] >> 2) == (a[i] >> 2)) seen = 1;
        if (!seen) cnt[bank_f(a[i])]++;
      end
    end
    for (int b = 0; b < NB; b++) if (cnt[b] > mx) mx = cnt[b];
    return (mx == 0) ? 1 : mx;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_random_inputs();
    for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = ADDR_W'($urandom);
    req_lane_valid = $urandom;
  endtask

  task automatic run_req(input string tag, input bit noise);
    logic [LANES-1:0] pend, got_all, e_srv;
    logic [NB-1:0] e_en;
    logic [NB*ROW_W-1:0] e_row;
    int n = 0;
    int ec;
    bit fin;
    ec = exp_cycles();
    @(negedge clk);
    for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = a[i];
    req_lane_valid = lv;
    req_valid = 1'b1;
    check(ready === 1'b1, "R7", {tag, " ready before request"}, 512'(ready), 512'(1));
    @(posedge clk);
    pend = lv;
    got_all = '0;
    fin = 0;
    while (!fin) begin
      @(negedge clk);
      n++;
      // independent model of one issue cycle
      e_en = '0; e_row = '0; e_srv = '0;
      for (int i = 0; i < LANES; i++) begin
        if (pend[i] && !e_en[bank_f(a[i])]) begin
          e_en[bank_f(a[i])] = 1'b1;
          e_row[bank_f(a[i])*ROW_W +: ROW_W] = ROW_W'(row_f(a[i]));
        end
      end
      for (int i = 0; i < LANES; i++)
        if (pend[i] && e_row[bank_f(a[i])*ROW_W +: ROW_W] == ROW_W'(row_f(a[i])))
          e_srv[i] = 1'b1;
      check(bank_en === e_en, "R1", {tag, " bank_en"}, 512'(bank_en), 512'(e_en));
      check(bank_row === e_row, "R1", {tag, " bank_row"}, 512'(bank_row), 512'(e_row));
      check(lane_served === e_srv, "R6", {tag, " lane_served"}, 512'(lane_served), 512'(e_srv));
      check(issue_valid === (e_en != '0), "R10", {tag, " issue_valid"},
            512'(issue_valid), 512'(e_en != '0));
      got_all = got_all | (lane_served & pend);
      pend = pend & ~e_srv;
      fin = (pend == '0);
      check(done === fin, "R8", {tag, " done"}, 512'(done), 512'(fin));
      check(ready === fin, "R7", {tag, " ready while issuing"}, 512'(ready), 512'(fin));
      if (fin || n > 40) begin
        req_valid = 1'b0;
        fin = 1;
      end else if (noise) begin
        req_valid = 1'b1;   // R7: ignored while ready is low
        drive_random_inputs();
      end else begin
        req_valid = 1'b0;
      end
    end
    check(n == ec, "R5", {tag, " issue cycles"}, 512'(n), 512'(ec));
    check(got_all === lv, "R9", {tag, " lanes served once"}, 512'(got_all), 512'(lv));
    @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'h1c5a_7e21));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready === 1'b1, "R10", "reset ready", 512'(ready), 512'(1));
    check(done === 1'b0, "R10", "reset done", 512'(done), 512'(0));
    check(issue_valid === 1'b0, "R10", "reset issue_valid", 512'(issue_valid), 512'(0));
    rst_n = 1'b1;

    // R1: word stride, one lane per bank, one cycle
    for (int i = 0; i < LANES; i++) a[i] = ADDR_W'(16'h0400 + i * 4);
    lv = '1; run_req("R1 stride4", 0);

    // R2: same word reached through different byte offsets
    for (int i = 0; i < LANES; i++) a[i] = ADDR_W'(16'h3a50 + (i % 4));
    lv = '1; run_req("R2 byte offsets", 0);

    // R4: every lane on one word
    for (int i = 0; i < LANES; i++) a[i] = 16'h7f8c;
    lv = '1; run_req("R4 broadcast", 0);

    // R3: two rows per bank
    for (int i = 0; i < LANES; i++) a[i] = ADDR_W'((i % 16) * 4 + (i / 16) * 128);
    lv = '1; run_req("R3 two-way", 0);

    // R5: worst case, all lanes in bank 0 at distinct rows
    for (int i = 0; i < LANES; i++) a[i] = ADDR_W'(i * 128);
    lv = '1; run_req("R5 worst case", 0);

    // R8: empty request
    lv = '0; run_req("R8 empty", 0);

    // R9: invalid lanes sit on conflicting rows
    for (int i = 0; i < LANES; i++) a[i] = ADDR_W'((i % 2) ? i * 128 : 16'h0200);
    lv = 32'h5555_5555; run_req("R9 sparse", 0);

    // R7: garbage held on the request inputs while busy
    for (int i = 0; i < LANES; i++) a[i] = ADDR_W'(i * 128 + 8);
    lv = '1; run_req("R7 busy noise", 1);

    // R6: random mixes, narrow and wide address ranges
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < LANES; i++)
        a[i] = (t % 2) ? ADDR_W'($urandom) : ADDR_W'($urandom % 1024);
      lv = (t % 3 == 0) ? '1 : LANES'($urandom);
      run_req("R6 random", t % 4 == 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule